// File: doc/BRIEF.md
# In-Order Transaction Retirement Tracker

This block follows the transactions that a producer commits to one descriptor ring. Each commit claims a run of consecutive ring slots from a credit pool and carries a tag. The block remembers which tag owns the final slot of that run. When the ring consumer later reports a finished slot index, the owning transaction retires together with every older transaction still outstanding. The retired transactions then wait in a completion queue, oldest first.

A client drains the completion queue through a valid/ready port. Each entry it removes gives that transaction's descriptor count back to the credit pool. A flush input moves every outstanding transaction into the completion queue with a cancelled mark, so that a channel can be torn down without waiting for the consumer.

Top module: `txn_retire_tracker`

## Requirements
- R1: After reset `done_valid` is 0, `credit_avail` equals RING_DEPTH, and `cpl_err` and `cancel_notify` are 0.
- R2: `commit_grant` is high in the same cycle exactly when `commit_valid` is high and 1 <= `commit_count` <= `credit_avail`. A granted commit lowers `credit_avail` by `commit_count` on the next cycle.
- R3: Granted commits claim consecutive ring indices, starting at index 0 after reset and wrapping modulo RING_DEPTH. A commit of n descriptors whose first index is i has its last descriptor at (i+n-1) mod RING_DEPTH. A `cpl_valid` report carrying that index retires the transaction.
- R4: A retirement also retires every older outstanding transaction, and they enter the completion queue in commit order.
- R5: `done_valid` is high exactly when the completion queue is non-empty. `done_tag`, `done_count` and `done_cancelled` then describe the oldest entry.
- R6: An entry is removed in a cycle where `done_valid` and `done_ready` are both high. While `done_ready` is low, the presented entry stays unchanged.
- R7: Removing an entry raises `credit_avail` by that entry's count on the next cycle, together with any commit taken in the same cycle.
- R8: A report whose index is not the last index of an outstanding transaction changes no state, and `cpl_err` pulses high on the next cycle. This covers intermediate indices and indices that have already retired.
- R9: `cancel_req` appends all outstanding transactions to the completion queue in commit order with `done_cancelled` = 1. `cancel_notify` pulses on the next cycle only if at least one transaction was outstanding.
- R10: If `cancel_req` and a granted commit fall in the same cycle, the new transaction stays outstanding and is not cancelled. If `cancel_req` and `cpl_valid` fall in the same cycle, the report is ignored and `cpl_err` stays low.
- R11: A report in the same cycle as a commit is judged against the state before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid | input | 1 | Commit request |
| commit_count | input | CNT_W | Descriptors in the committed transaction |
| commit_tag | input | TAG_W | Tag of the committed transaction |
| commit_grant | output | 1 | Commit accepted this cycle |
| credit_avail | output | CNT_W | Free descriptor credits |
| cpl_valid | input | 1 | Consumer reports a finished ring index |
| cpl_index | input | IDX_W | Reported ring index |
| cpl_err | output | 1 | Pulse: previous report matched no outstanding transaction |
| cancel_req | input | 1 | Flush all outstanding transactions |
| cancel_notify | output | 1 | Pulse: previous flush moved at least one transaction |
| done_valid | output | 1 | Completion queue non-empty |
| done_ready | input | 1 | Client takes the presented entry |
| done_tag | output | TAG_W | Tag of oldest completed transaction |
| done_count | output | CNT_W | Descriptor count of that transaction |
| done_cancelled | output | 1 | That transaction was flushed, not finished |

## Verification
The sharpest overlaps are a flush arriving with a commit or with a completion report, and a pop arriving in the same cycle as a retirement that extends the queue behind the head. The random phase enables commits, reports, pops and occasional flushes on the same cycles with independent probabilities. Directed steps force each pairing on purpose. A reference model in the bench applies a fixed order within each cycle: pop from the old head, then flush or retire, then append the commit. It judges the grant in the cycle itself and judges the queue head, credits and pulses one cycle later.

// File: rtl/trt_pkg.sv
package trt_pkg;
   // index width for a ring of the given depth
   function automatic int idx_bits(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction
   // width able to hold the value depth itself
   function automatic int cnt_bits(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/trt_slot_map.sv
module trt_slot_map #(
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 4,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [SLOT_W-1:0] rd_slot
);
   logic [DEPTH-1:0]  vld_q;
   logic [SLOT_W-1:0] slot_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            vld_q[e] <= 1'b0;
         else if (wr_en && wr_idx == IDX_W'(e))
            vld_q[e] <= 1'b1;
      end
      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(e))
            slot_q[e] <= wr_slot;
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign rd_slot  = slot_q[rd_idx];

   AST_MAP_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_idx)]); // R3
endmodule

// File: rtl/trt_credit.sv
module trt_credit #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_req,
   input  logic [CNT_W-1:0] take_cnt,
   input  logic             give_en,
   input  logic [CNT_W-1:0] give_cnt,
   output logic             grant,
   output logic [CNT_W-1:0] credit
);
   logic [CNT_W-1:0] credit_q;

   assign grant  = take_req && (take_cnt != '0) && (take_cnt <= credit_q);
   assign credit = credit_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         credit_q <= CNT_W'(DEPTH);
      else
         credit_q <= credit_q - (grant ? take_cnt : '0) + (give_en ? give_cnt : '0);
   end

   AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      credit_q <= CNT_W'(DEPTH)); // R7
   AST_CREDIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !give_en) |=> credit_q == $past(credit_q) - $past(take_cnt)); // R2
endmodule

// File: rtl/trt_txn_queue.sv
module trt_txn_queue #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 8,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   input  logic [CNT_W-1:0] push_cnt,
   input  logic [IDX_W-1:0] push_last,
   output logic [IDX_W-1:0] tail_slot,
   input  logic [IDX_W-1:0] probe_slot,
   input  logic [IDX_W-1:0] probe_idx,
   output logic             probe_hit,
   input  logic             retire,
   input  logic             cancel,
   output logic             pend_any,
   input  logic             pop,
   output logic             head_valid,
   output logic [TAG_W-1:0] head_tag,
   output logic [CNT_W-1:0] head_cnt,
   output logic             head_canc
);
   localparam int PTR_W = IDX_W + 1;

   logic [PTR_W-1:0] head_p, done_p, tail_p, pend_n;
   logic [IDX_W-1:0] off;
   logic [TAG_W-1:0] tag_q  [DEPTH];
   logic [CNT_W-1:0] cnt_q  [DEPTH];
   logic [IDX_W-1:0] last_q [DEPTH];
   logic [DEPTH-1:0] canc_q;

   assign tail_slot  = tail_p[IDX_W-1:0];
   assign pend_n     = tail_p - done_p;
   assign pend_any   = (pend_n != '0);
   assign off        = probe_slot - done_p[IDX_W-1:0];
   assign probe_hit  = ({1'b0, off} < pend_n) && (last_q[probe_slot] == probe_idx);
   assign head_valid = (head_p != done_p);
   assign head_tag   = tag_q[head_p[IDX_W-1:0]];
   assign head_cnt   = cnt_q[head_p[IDX_W-1:0]];
   assign head_canc  = canc_q[head_p[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_p <= '0;
         done_p <= '0;
         tail_p <= '0;
      end else begin
         head_p <= head_p + PTR_W'(pop && head_valid);
         tail_p <= tail_p + PTR_W'(push);
         if (cancel)
            done_p <= tail_p;
         else if (retire)
            done_p <= done_p + PTR_W'(off) + PTR_W'(1);
      end
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic [IDX_W-1:0] rel;
      logic             in_pend, wr_here;
      assign rel     = IDX_W'(s) - done_p[IDX_W-1:0];
      assign in_pend = ({1'b0, rel} < pend_n);
      assign wr_here = push && (tail_p[IDX_W-1:0] == IDX_W'(s));
      always_ff @(posedge clk) begin
         if (!rst_n)
            canc_q[s] <= 1'b0;
         else if (wr_here)
            canc_q[s] <= 1'b0;
         else if (cancel && in_pend)
            canc_q[s] <= 1'b1;
      end
      always_ff @(posedge clk) begin
         if (wr_here) begin
            tag_q[s]  <= push_tag;
            cnt_q[s]  <= push_cnt;
            last_q[s] <= push_last;
         end
      end
   end

   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !pop) |=> head_valid && $stable(head_tag) && $stable(head_cnt)); // R6
   AST_DONE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_p - head_p) <= (tail_p - head_p)); // R4
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel && !push) |=> !pend_any); // R9
   AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_p - head_p) <= PTR_W'(DEPTH)); // R2
endmodule

// File: rtl/txn_retire_tracker.sv
module txn_retire_tracker #(
   parameter  int RING_DEPTH = 16,
   parameter  int TAG_W      = 8,
   localparam int IDX_W      = trt_pkg::idx_bits(RING_DEPTH),
   localparam int CNT_W      = trt_pkg::cnt_bits(RING_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit_valid,
   input  logic [CNT_W-1:0] commit_count,
   input  logic [TAG_W-1:0] commit_tag,
   output logic             commit_grant,
   output logic [CNT_W-1:0] credit_avail,
   input  logic             cpl_valid,
   input  logic [IDX_W-1:0] cpl_index,
   output logic             cpl_err,
   input  logic             cancel_req,
   output logic             cancel_notify,
   output logic             done_valid,
   input  logic             done_ready,
   output logic [TAG_W-1:0] done_tag,
   output logic [CNT_W-1:0] done_count,
   output logic             done_cancelled
);
   initial begin : elab_chk
      assert (RING_DEPTH >= 2 && (RING_DEPTH & (RING_DEPTH - 1)) == 0)
         else $error("RING_DEPTH must be a power of two of at least 2");
      assert (TAG_W >= 1) else $error("TAG_W must be positive");
   end

   logic [IDX_W-1:0] wr_idx_q, last_idx, tail_slot, map_slot;
   logic             map_valid, probe_hit, pend_any, retire, pop, err_q, notify_q;

   assign last_idx = wr_idx_q + IDX_W'(commit_count) - IDX_W'(1);
   assign retire   = cpl_valid && !cancel_req && map_valid && probe_hit;
   assign pop      = done_valid && done_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx_q <= '0;
         err_q    <= 1'b0;
         notify_q <= 1'b0;
      end else begin
         if (commit_grant)
            wr_idx_q <= last_idx + IDX_W'(1);
         err_q    <= cpl_valid && !cancel_req && !(map_valid && probe_hit);
         notify_q <= cancel_req && pend_any;
      end
   end

   assign cpl_err       = err_q;
   assign cancel_notify = notify_q;

   trt_credit #(.DEPTH(RING_DEPTH), .CNT_W(CNT_W)) u_credit (
      .clk(clk), .rst_n(rst_n),
      .take_req(commit_valid), .take_cnt(commit_count),
      .give_en(pop), .give_cnt(done_count),
      .grant(commit_grant), .credit(credit_avail));

   trt_slot_map #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W), .SLOT_W(IDX_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit_grant), .wr_idx(last_idx), .wr_slot(tail_slot),
      .rd_idx(cpl_index), .rd_valid(map_valid), .rd_slot(map_slot));

   trt_txn_queue #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(commit_grant), .push_tag(commit_tag), .push_cnt(commit_count),
      .push_last(last_idx), .tail_slot(tail_slot),
      .probe_slot(map_slot), .probe_idx(cpl_index), .probe_hit(probe_hit),
      .retire(retire), .cancel(cancel_req), .pend_any(pend_any),
      .pop(pop), .head_valid(done_valid), .head_tag(done_tag),
      .head_cnt(done_count), .head_canc(done_cancelled));

   AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_notify |-> $past(cancel_req)); // R9
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_err |-> $past(cpl_valid) && !$past(cancel_req)); // R10
   AST_ERR_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !cancel_req && !retire && !done_ready) |=> $stable(done_valid) || $past(done_valid)); // R8
endmodule

// File: tb/txn_retire_tracker_tb_top.sv
module txn_retire_tracker_tb_top;
   localparam int D     = 16;
   localparam int TAG_W = 8;
   localparam int IDX_W = 4;
   localparam int CNT_W = 5;

   typedef struct {
      int tag;
      int cnt;
      int last;
      bit canc;
   } ent_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic commit_valid = 1'b0, cpl_valid = 1'b0, cancel_req = 1'b0, done_ready = 1'b0;
   logic [CNT_W-1:0] commit_count = '0;
   logic [TAG_W-1:0] commit_tag = '0;
   logic [IDX_W-1:0] cpl_index = '0;
   logic commit_grant, cpl_err, cancel_notify, done_valid, done_cancelled;
   logic [CNT_W-1:0] credit_avail, done_count;
   logic [TAG_W-1:0] done_tag;

   always #5 clk = ~clk;

   txn_retire_tracker #(.RING_DEPTH(D), .TAG_W(TAG_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .commit_valid(commit_valid), .commit_count(commit_count), .commit_tag(commit_tag),
      .commit_grant(commit_grant), .credit_avail(credit_avail),
      .cpl_valid(cpl_valid), .cpl_index(cpl_index), .cpl_err(cpl_err),
      .cancel_req(cancel_req), .cancel_notify(cancel_notify),
      .done_valid(done_valid), .done_ready(done_ready), .done_tag(done_tag),
      .done_count(done_count), .done_cancelled(done_cancelled));

   int checks = 0, fails = 0;
   ent_t pq[$], cq[$];
   int m_credit = D, m_widx = 0;
   bit exp_err = 0, exp_notify = 0;

   function automatic void chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endfunction

   function automatic bit exp_grant(bit cv, int cnt);
      return cv && cnt >= 1 && cnt <= m_credit;
   endfunction

   function automatic int find_pending(int idx);
      for (int k = 0; k < pq.size(); k++)
         if (pq[k].last == idx) return k;
      return -1;
   endfunction

   task automatic check_outputs(string req);
      chk(req, "done_valid", int'(done_valid), int'(cq.size() > 0));
      if (cq.size() > 0) begin
         chk(req, "done_tag", int'(done_tag), cq[0].tag);
         chk(req, "done_count", int'(done_count), cq[0].cnt);
         chk(req, "done_cancelled", int'(done_cancelled), int'(cq[0].canc));
      end
      chk("R7", "credit_avail", int'(credit_avail), m_credit);
      chk("R8", "cpl_err", int'(cpl_err), int'(exp_err));
      chk("R9", "cancel_notify", int'(cancel_notify), int'(exp_notify));
   endtask

   // one cycle: drive at negedge, judge grant, advance model, judge registered outputs
   task automatic step(bit cv, int cnt, int tag, bit pv, int pidx, bit cx, bit rdy, string req);
      bit g;
      int give;
      int k;
      commit_valid = cv; commit_count = CNT_W'(cnt); commit_tag = TAG_W'(tag);
      cpl_valid = pv; cpl_index = IDX_W'(pidx); cancel_req = cx; done_ready = rdy;
      #1;
      g = exp_grant(cv, cnt);
      chk("R2", "commit_grant", int'(commit_grant), int'(g));
      give = 0;
      if (rdy && cq.size() > 0) begin
         give = cq[0].cnt;
         void'(cq.pop_front());
      end
      exp_err = 0; exp_notify = 0;
      if (cx) begin
         exp_notify = (pq.size() > 0);
         while (pq.size() > 0) begin
            ent_t e = pq.pop_front();
            e.canc = 1;
            cq.push_back(e);
         end
      end else if (pv) begin
         k = find_pending(pidx);
         if (k < 0) exp_err = 1;
         else for (int j = 0; j <= k; j++) cq.push_back(pq.pop_front());
      end
      if (g) begin
         ent_t n;
         n.tag = tag & 8'hff; n.cnt = cnt; n.last = (m_widx + cnt - 1) % D; n.canc = 0;
         pq.push_back(n);
         m_widx = (m_widx + cnt) % D;
         m_credit -= cnt;
      end
      m_credit += give;
      @(posedge clk);
      @(negedge clk);
      check_outputs(req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1234abcd));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "done_valid", int'(done_valid), 0);
      chk("R1", "credit_avail", int'(credit_avail), D);
      chk("R1", "cpl_err", int'(cpl_err), 0);
      chk("R1", "cancel_notify", int'(cancel_notify), 0);
      @(negedge clk);

      // R3: three commits, last indices 1, 2, 5
      step(1, 2, 8'h11, 0, 0, 0, 0, "R3");
      step(1, 1, 8'h22, 0, 0, 0, 0, "R3");
      step(1, 3, 8'h33, 0, 0, 0, 0, "R3");
      // R2: zero count and over-credit refused
      step(1, 0, 8'h44, 0, 0, 0, 0, "R2");
      step(1, 11, 8'h44, 0, 0, 0, 0, "R2");
      // R4: report index 2 retires the first two in order
      step(0, 0, 0, 1, 2, 0, 0, "R4");
      chk("R4", "head is oldest", int'(done_tag), 8'h11);
      // R8: intermediate index 3 and retired index 1 flagged
      step(0, 0, 0, 1, 3, 0, 0, "R8");
      step(0, 0, 0, 1, 1, 0, 0, "R8");
      // R6: hold without ready, then pop while retiring index 5 (R11: commit same cycle)
      step(0, 0, 0, 0, 0, 0, 0, "R6");
      step(1, 2, 8'h55, 1, 5, 0, 1, "R5");
      // R11: report of index just being committed is judged before the commit
      step(1, 1, 8'h66, 1, 8, 0, 1, "R11");
      // R10: cancel with commit; cancel with report
      step(1, 2, 8'h77, 1, 7, 1, 0, "R10");
      step(0, 0, 0, 1, 10, 1, 0, "R9");
      step(0, 0, 0, 0, 0, 1, 0, "R9");
      step(0, 0, 0, 1, 10, 0, 0, "R10");
      for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 1, "R6");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit cv = ($urandom % 3) != 0;
         int cnt = $urandom % 7;
         bit pv = ($urandom % 2) != 0;
         int pidx = $urandom % D;
         bit cx = ($urandom % 40) == 0;
         bit rdy = ($urandom % 3) != 0;
         if (pq.size() > 0 && ($urandom % 3) != 0)
            pidx = pq[$urandom % pq.size()].last;
         step(cv, cnt, $urandom % 256, pv, pidx, cx, rdy, "R4");
      end
      for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 1, 1, "R7");
      chk("R7", "credit restored", int'(credit_avail), D);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule